// File: doc/BRIEF.md
# Backplane single-cycle slave responder

This block is the slave side of an asynchronous, big-endian parallel backplane bus, used for single read and write cycles only. A master sets up the address, the 6-bit address modifier, the long-word line and the direction, then pulls the address strobe low. The block brings the strobes into its own clock domain and decides whether the cycle is meant for it. Selection needs two things: the address bits inside the configured address width must match a base address, and the modifier code must be one of an accepted set.

When a data strobe arrives, the block works out the transfer size and the byte lane from the two data strobes, the long-word line and A1, since the bus has no A0 line. It then does one access on a simple local register port and finishes the handshake with an acknowledge. For a combination it cannot serve, it raises a bus error instead. The acknowledge or error is held until the master has released both data strobes.

All protocol lines are active low. Address, modifier and data lines are active high. The local port addresses 32-bit words with byte enables, and byte offset 0 is the most significant byte.

Top module: `bp_slave_responder`

## Requirements
- R1: While reset is high, and right after it is released, `bus_dtack_n` and `bus_berr_n` are high, `bus_doe` is low and no local access is issued.
- R2: A cycle is selected only when the modifier code is in the accepted set (0x39 and 0x3D by default) and address bits [ADDR_BITS-1:WIN_BITS] equal the same bits of the base address (0x00AB0000, ADDR_BITS=24, WIN_BITS=8 by default). Address bits at or above ADDR_BITS are ignored.
- R3: 32-bit transfer: long-word low and both strobes low, with A1=0. It uses bus data bits [31:0] and the whole local word.
- R4: 16-bit transfer: long-word high and both strobes low. It uses bus bits [15:0]. A1=0 maps to local bits [31:16] and A1=1 maps to local bits [15:0].
- R5: 8-bit transfer: long-word high and exactly one strobe low. DS1 low selects the even byte on bus bits [15:8]. DS0 low selects the odd byte on bus bits [7:0]. The byte offset is {A1, odd}, and offset 0 is local bits [31:24].
- R6: A served write issues exactly one local write pulse, with byte enables that match the lane. A served read drives the selected data, with all unused bus bits zero.
- R7: A 32-bit request with A1=1, or a single strobe with long-word low, is answered with a bus error and makes no local write.
- R8: A cycle that is not selected gets neither an acknowledge nor a bus error.
- R9: The acknowledge or error appears within 6 clocks of the data strobe. It stays asserted while any data strobe is low and is removed once both are high.
- R10: `bus_doe` is high only during a served read, and only while the acknowledge is asserted.
- R11: The acknowledge and the bus error are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds0_n | input | 1 | Data strobe 0 (odd byte), active low |
| bus_ds1_n | input | 1 | Data strobe 1 (even byte), active low |
| bus_lword_n | input | 1 | Long-word line, active low |
| bus_write_n | input | 1 | Low for write, high for read |
| bus_addr | input | 31 | Address lines A[31:1] |
| bus_am | input | 6 | Address modifier code |
| bus_din | input | 32 | Data lines as seen by the slave |
| bus_dout | output | 32 | Read data for the data lines |
| bus_doe | output | 1 | Enable for the read data drivers |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| bus_berr_n | output | 1 | Bus error, active low |
| loc_wr | output | 1 | Local write pulse |
| loc_rd | output | 1 | Local read pulse |
| loc_word | output | WIN_BITS-2 | Local word index |
| loc_be | output | 4 | Local byte enables, bit 3 = bits [31:24] |
| loc_wdata | output | 32 | Local write data, replicated across lanes |
| loc_rdata | input | 32 | Local read data, valid in the same cycle as loc_rd |

## Verification
The bench writes a word, then overwrites parts of it with 16-bit and single-byte writes on both halves and both byte strobes. It reads the word back at every width. A design with swapped endianness or a swapped strobe-to-byte mapping would return the bytes in the wrong order or on the wrong lane. It also sends a 32-bit request with A1 set and a single strobe with long-word low, then reads the target word back. A design that misses these cases would acknowledge them or corrupt the word. Cycles with a foreign modifier code or a foreign address must stay silent, while an address that differs only above the address width must still be served. For every cycle the bench confirms that the acknowledge holds until the strobes are gone, and that the drivers turn off with it.

// File: rtl/bp_slave_pkg.sv
package bp_slave_pkg;

    typedef enum logic [1:0] {
        SZ_D8  = 2'd0,
        SZ_D16 = 2'd1,
        SZ_D32 = 2'd2
    } xfer_size_e;

    typedef struct packed {
        logic       ok;
        xfer_size_e size;
        logic [1:0] ofs;
        logic [3:0] be;
    } lane_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_XFER,
        ST_ACK,
        ST_DONE
    } hs_state_e;

    // size and byte lane from the long-word line, both strobes and A1
    function automatic lane_t lane_decode(input logic lword_n, input logic ds1_n,
                                          input logic ds0_n, input logic a1);
        lane_t r;
        r.ok   = 1'b0;
        r.size = SZ_D8;
        r.ofs  = 2'd0;
        r.be   = 4'b0000;
        case ({lword_n, ds1_n, ds0_n})
            3'b000: begin
                r.size = SZ_D32;
                r.be   = 4'b1111;
                r.ok   = !a1;
            end
            3'b100: begin
                r.size = SZ_D16;
                r.ofs  = {a1, 1'b0};
                r.be   = a1 ? 4'b0011 : 4'b1100;
                r.ok   = 1'b1;
            end
            3'b101: begin
                r.ofs = {a1, 1'b0};
                r.be  = 4'b1000 >> r.ofs;
                r.ok  = 1'b1;
            end
            3'b110: begin
                r.ofs = {a1, 1'b1};
                r.be  = 4'b1000 >> r.ofs;
                r.ok  = 1'b1;
            end
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction

    // replicate the bus lane into every local lane; byte enables pick
    function automatic logic [31:0] wr_spread(input lane_t l, input logic [31:0] d);
        case (l.size)
            SZ_D32:  return d;
            SZ_D16:  return {2{d[15:0]}};
            default: return {4{l.ofs[0] ? d[7:0] : d[15:8]}};
        endcase
    endfunction

    function automatic logic [31:0] rd_pick(input lane_t l, input logic [31:0] w);
        logic [7:0] b;
        case (l.ofs)
            2'd0:    b = w[31:24];
            2'd1:    b = w[23:16];
            2'd2:    b = w[15:8];
            default: b = w[7:0];
        endcase
        case (l.size)
            SZ_D32:  return w;
            SZ_D16:  return {16'h0, l.ofs[1] ? w[15:0] : w[31:16]};
            default: return l.ofs[0] ? {24'h0, b} : {16'h0, b, 8'h0};
        endcase
    endfunction

endpackage

// File: rtl/bp_strobe_sync.sv
module bp_strobe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_n,
    output logic [W-1:0] q_n
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '1;
                else if (s == 0) stg[s] <= d_n;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_n = stg[STAGES-1];
endmodule

// File: rtl/bp_cycle_decode.sv
module bp_cycle_decode
    import bp_slave_pkg::*;
#(
    parameter int          ADDR_BITS = 24,
    parameter int          WIN_BITS  = 8,
    parameter logic [31:0] BASE_ADDR = 32'h00AB_0000,
    parameter logic [63:0] AM_MASK   = 64'h2200_0000_0000_0000,
    localparam int         WORD_W    = WIN_BITS - 2
) (
    input  logic [ADDR_BITS-1:1] addr,
    input  logic [5:0]           am,
    input  logic                 lword_n,
    input  logic [1:0]           ds_s,
    output logic                 hit,
    output lane_t                lane,
    output logic [WORD_W-1:0]    word
);
    always_comb begin
        hit  = AM_MASK[am] && (addr[ADDR_BITS-1:WIN_BITS] == BASE_ADDR[ADDR_BITS-1:WIN_BITS]);
        lane = lane_decode(lword_n, ds_s[1], ds_s[0], addr[1]);
        word = addr[WIN_BITS-1:2];
    end
endmodule

// File: rtl/bp_hs_fsm.sv
module bp_hs_fsm
    import bp_slave_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_s,
    input  logic [1:0]        ds_s,
    input  logic              hit,
    input  lane_t             lane,
    input  logic              write_n,
    input  logic [31:0]       din,
    input  logic [WORD_W-1:0] word_in,
    input  logic [31:0]       loc_rdata,
    output logic              dtack_n,
    output logic              berr_n,
    output logic              d_oe,
    output logic [31:0]       dout,
    output logic              sel_active,
    output logic              loc_wr,
    output logic              loc_rd,
    output logic [WORD_W-1:0] loc_word,
    output logic [3:0]        loc_be,
    output logic [31:0]       loc_wdata
);
    hs_state_e state;
    logic      xfer;

    always_comb begin
        xfer       = (state == ST_XFER);
        loc_wr     = xfer && lane.ok && !write_n;
        loc_rd     = xfer && lane.ok && write_n;
        loc_be     = lane.be;
        loc_wdata  = wr_spread(lane, din);
        loc_word   = word_in;
        sel_active = (state == ST_SEL) || (state == ST_XFER) || (state == ST_ACK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            dtack_n <= 1'b1;
            berr_n  <= 1'b1;
            d_oe    <= 1'b0;
            dout    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (!as_s) state <= hit ? ST_SEL : ST_DONE;
                ST_SEL: begin
                    if (as_s) state <= ST_IDLE;
                    else if (ds_s != 2'b11) state <= ST_XFER;
                end
                ST_XFER: begin
                    state <= ST_ACK;
                    if (lane.ok) begin
                        dtack_n <= 1'b0;
                        d_oe    <= write_n;
                        dout    <= write_n ? rd_pick(lane, loc_rdata) : 32'h0;
                    end else begin
                        berr_n <= 1'b0;
                    end
                end
                ST_ACK: if (ds_s == 2'b11) begin
                    dtack_n <= 1'b1;
                    berr_n  <= 1'b1;
                    d_oe    <= 1'b0;
                    state   <= ST_DONE;
                end
                default: if (as_s) state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bp_slave_responder.sv
module bp_slave_responder
    import bp_slave_pkg::*;
#(
    parameter int          ADDR_BITS   = 24,
    parameter int          WIN_BITS    = 8,
    parameter logic [31:0] BASE_ADDR   = 32'h00AB_0000,
    parameter logic [63:0] AM_MASK     = 64'h2200_0000_0000_0000,
    parameter int          SYNC_STAGES = 2,
    localparam int         WORD_W      = WIN_BITS - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_as_n,
    input  logic              bus_ds0_n,
    input  logic              bus_ds1_n,
    input  logic              bus_lword_n,
    input  logic              bus_write_n,
    input  logic [31:1]       bus_addr,
    input  logic [5:0]        bus_am,
    input  logic [31:0]       bus_din,
    output logic [31:0]       bus_dout,
    output logic              bus_doe,
    output logic              bus_dtack_n,
    output logic              bus_berr_n,
    output logic              loc_wr,
    output logic              loc_rd,
    output logic [WORD_W-1:0] loc_word,
    output logic [3:0]        loc_be,
    output logic [31:0]       loc_wdata,
    input  logic [31:0]       loc_rdata
);
    logic [2:0]        strb_s;
    logic              as_s;
    logic [1:0]        ds_s;
    logic              hit;
    lane_t             lane;
    logic [WORD_W-1:0] word;
    logic              sel_active;

    bp_strobe_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_n ({bus_as_n, bus_ds1_n, bus_ds0_n}),
        .q_n (strb_s)
    );
    assign as_s = strb_s[2];
    assign ds_s = strb_s[1:0];

    generate
        if (ADDR_BITS < 32) begin : g_hi_ignored
            logic unused_hi;
            assign unused_hi = ^bus_addr[31:ADDR_BITS];
        end
    endgenerate

    bp_cycle_decode #(
        .ADDR_BITS (ADDR_BITS),
        .WIN_BITS  (WIN_BITS),
        .BASE_ADDR (BASE_ADDR),
        .AM_MASK   (AM_MASK)
    ) i_dec (
        .addr    (bus_addr[ADDR_BITS-1:1]),
        .am      (bus_am),
        .lword_n (bus_lword_n),
        .ds_s    (ds_s),
        .hit     (hit),
        .lane    (lane),
        .word    (word)
    );

    bp_hs_fsm #(.WORD_W(WORD_W)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .as_s       (as_s),
        .ds_s       (ds_s),
        .hit        (hit),
        .lane       (lane),
        .write_n    (bus_write_n),
        .din        (bus_din),
        .word_in    (word),
        .loc_rdata  (loc_rdata),
        .dtack_n    (bus_dtack_n),
        .berr_n     (bus_berr_n),
        .d_oe       (bus_doe),
        .dout       (bus_dout),
        .sel_active (sel_active),
        .loc_wr     (loc_wr),
        .loc_rd     (loc_rd),
        .loc_word   (loc_word),
        .loc_be     (loc_be),
        .loc_wdata  (loc_wdata)
    );
endmodule

// File: rtl/bp_slave_checker.sv
module bp_slave_checker (
    input logic       clk,
    input logic       rst,
    input logic       dtack_n,
    input logic       berr_n,
    input logic       d_oe,
    input logic [1:0] ds_s,
    input logic       sel_active,
    input logic       loc_wr,
    input logic       loc_rd
);
    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(!dtack_n && !berr_n));

    p_unsel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n || !berr_n) |-> sel_active);

    p_hold_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && ds_s != 2'b11) |=> !dtack_n);

    p_hold_err_r9: assert property (@(posedge clk) disable iff (rst)
        (!berr_n && ds_s != 2'b11) |=> !berr_n);

    p_oe_window_r10: assert property (@(posedge clk) disable iff (rst)
        d_oe |-> !dtack_n);

    p_single_access_r6: assert property (@(posedge clk) disable iff (rst)
        (loc_wr || loc_rd) |=> !(loc_wr || loc_rd));

    p_access_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loc_wr, loc_rd}));

    p_err_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        !berr_n |-> !loc_wr);
endmodule

bind bp_slave_responder bp_slave_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .dtack_n    (bus_dtack_n),
    .berr_n     (bus_berr_n),
    .d_oe       (bus_doe),
    .ds_s       (ds_s),
    .sel_active (sel_active),
    .loc_wr     (loc_wr),
    .loc_rd     (loc_rd)
);

// File: tb/test_bp_slave_responder.sv
module test_bp_slave_responder;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 6;
    localparam int NVEC       = 20;

    typedef struct packed {
        logic        wr;
        logic [5:0]  am;
        logic [31:0] addr;
        logic        lw;
        logic        ds1;
        logic        ds0;
        logic [31:0] data;
        logic [1:0]  resp;   // 0 silent, 1 acknowledge, 2 bus error
        logic [31:0] expd;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 6'h39, 32'h00AB0010, 1'b0, 1'b0, 1'b0, 32'h11223344, 2'd1, 32'h0},
        '{1'b0, 6'h39, 32'h00AB0010, 1'b0, 1'b0, 1'b0, 32'h0,        2'd1, 32'h11223344},
        '{1'b1, 6'h39, 32'h00AB0010, 1'b1, 1'b0, 1'b0, 32'h0000AAAA, 2'd1, 32'h0},
        '{1'b0, 6'h39, 32'h00AB0010, 1'b0, 1'b0, 1'b0, 32'h0,        2'd1, 32'hAAAA3344},
        '{1'b1, 6'h39, 32'h00AB0012, 1'b1, 1'b0, 1'b1, 32'h00005500, 2'd1, 32'h0},
        '{1'b1, 6'h39, 32'h00AB0012, 1'b1, 1'b1, 1'b0, 32'h00000066, 2'd1, 32'h0},
        '{1'b0, 6'h39, 32'h00AB0010, 1'b0, 1'b0, 1'b0, 32'h0,        2'd1, 32'hAAAA5566},
        '{1'b0, 6'h39, 32'h00AB0012, 1'b1, 1'b0, 1'b0, 32'h0,        2'd1, 32'h00005566},
        '{1'b1, 6'h3D, 32'h00AB0020, 1'b0, 1'b0, 1'b0, 32'h0A0B0C0D, 2'd1, 32'h0},
        '{1'b0, 6'h39, 32'h00AB0020, 1'b1, 1'b0, 1'b1, 32'h0,        2'd1, 32'h00000A00},
        '{1'b0, 6'h39, 32'h00AB0020, 1'b1, 1'b1, 1'b0, 32'h0,        2'd1, 32'h0000000B},
        '{1'b0, 6'h39, 32'h00AB0022, 1'b1, 1'b0, 1'b1, 32'h0,        2'd1, 32'h00000C00},
        '{1'b0, 6'h39, 32'h00AB0012, 1'b0, 1'b0, 1'b0, 32'h0,        2'd2, 32'h0},
        '{1'b1, 6'h39, 32'h00AB0022, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 2'd2, 32'h0},
        '{1'b1, 6'h39, 32'h00AB0020, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 2'd2, 32'h0},
        '{1'b0, 6'h39, 32'h00AB0020, 1'b0, 1'b0, 1'b0, 32'h0,        2'd1, 32'h0A0B0C0D},
        '{1'b1, 6'h09, 32'h00AB0020, 1'b0, 1'b0, 1'b0, 32'h12345678, 2'd0, 32'h0},
        '{1'b1, 6'h39, 32'h00AC0020, 1'b0, 1'b0, 1'b0, 32'h12345678, 2'd0, 32'h0},
        '{1'b0, 6'h3D, 32'hFFAB0020, 1'b0, 1'b0, 1'b0, 32'h0,        2'd1, 32'h0A0B0C0D},
        '{1'b0, 6'h39, 32'h00AB0010, 1'b1, 1'b1, 1'b0, 32'h0,        2'd1, 32'h000000AA}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_as_n = 1'b1, bus_ds0_n = 1'b1, bus_ds1_n = 1'b1;
    logic              bus_lword_n = 1'b1, bus_write_n = 1'b1;
    logic [31:1]       bus_addr = '0;
    logic [5:0]        bus_am = '0;
    logic [31:0]       bus_din = '0;
    logic [31:0]       bus_dout;
    logic              bus_doe, bus_dtack_n, bus_berr_n;
    logic              loc_wr, loc_rd;
    logic [WORD_W-1:0] loc_word;
    logic [3:0]        loc_be;
    logic [31:0]       loc_wdata, loc_rdata;

    logic [31:0] mem [64];
    int          wr_count = 0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_slave_responder i_bp_slave_responder (
        .clk(clk), .rst(rst),
        .bus_as_n(bus_as_n), .bus_ds0_n(bus_ds0_n), .bus_ds1_n(bus_ds1_n),
        .bus_lword_n(bus_lword_n), .bus_write_n(bus_write_n),
        .bus_addr(bus_addr), .bus_am(bus_am), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_dtack_n(bus_dtack_n), .bus_berr_n(bus_berr_n),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_word(loc_word),
        .loc_be(loc_be), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
    );

    // local register file behind the port
    assign loc_rdata = mem[loc_word];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'h0;
        end else if (loc_wr) begin
            for (int b = 0; b < 4; b++)
                if (loc_be[b]) mem[loc_word][8*b +: 8] <= loc_wdata[8*b +: 8];
        end
        if (loc_wr) wr_count <= wr_count + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int got = 0;
        int lat = 0;
        int wc0;
        @(negedge clk);
        bus_addr    = v.addr[31:1];
        bus_am      = v.am;
        bus_lword_n = v.lw;
        bus_write_n = !v.wr;
        bus_din     = v.wr ? v.data : 32'h0;
        wc0         = wr_count;
        @(negedge clk);
        bus_as_n = 1'b0;
        @(negedge clk);
        bus_ds1_n = v.ds1;
        bus_ds0_n = v.ds0;
        for (int i = 0; i < 10 && got == 0; i++) begin
            @(negedge clk);
            lat++;
            if (!bus_dtack_n && !bus_berr_n)
                check(0, "R11", $sformatf("vec %0d both asserted", idx), 32'h0, 32'h1);
            if (!bus_dtack_n) got = 1;
            else if (!bus_berr_n) got = 2;
        end
        // R2 R7 R8: response kind
        check(got == int'(v.resp), "R2/R7/R8", $sformatf("vec %0d response", idx),
              32'(got), 32'(v.resp));
        if (got != 0) begin
            check(lat <= 6, "R9", $sformatf("vec %0d latency", idx), 32'(lat), 32'd6);
            if (got == 1 && !v.wr) begin
                check(bus_doe == 1'b1, "R10", $sformatf("vec %0d read drivers on", idx),
                      32'(bus_doe), 32'd1);
                // R3 R4 R5 R6: lane and byte order of read data
                check(bus_dout == v.expd, "R3/R4/R5/R6", $sformatf("vec %0d read data", idx),
                      bus_dout, v.expd);
            end else begin
                check(bus_doe == 1'b0, "R10", $sformatf("vec %0d drivers off", idx),
                      32'(bus_doe), 32'd0);
            end
            repeat (3) @(negedge clk);
            check((got == 1) ? !bus_dtack_n : !bus_berr_n, "R9",
                  $sformatf("vec %0d hold while strobes low", idx), 32'd0, 32'd1);
        end
        bus_ds1_n = 1'b1;
        bus_ds0_n = 1'b1;
        for (int i = 0; i < 10 && !(bus_dtack_n && bus_berr_n); i++) @(negedge clk);
        check(bus_dtack_n && bus_berr_n, "R9", $sformatf("vec %0d release", idx),
              {30'h0, bus_dtack_n, bus_berr_n}, 32'h3);
        check(bus_doe == 1'b0, "R10", $sformatf("vec %0d drivers after release", idx),
              32'(bus_doe), 32'd0);
        // R6 R7: local write count
        check((wr_count - wc0) == ((v.wr && got == 1) ? 1 : 0), "R6/R7",
              $sformatf("vec %0d local writes", idx), 32'(wr_count - wc0),
              (v.wr && got == 1) ? 32'd1 : 32'd0);
        bus_as_n = 1'b1;
        bus_din  = 32'h0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_dtack_n && bus_berr_n && !bus_doe && !loc_wr && !loc_rd, "R1",
              "outputs in reset", {28'h0, bus_dtack_n, bus_berr_n, bus_doe, loc_wr},
              32'hC);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(bus_dtack_n && bus_berr_n && !bus_doe && !loc_wr && !loc_rd, "R1",
              "outputs after reset", {28'h0, bus_dtack_n, bus_berr_n, bus_doe, loc_wr},
              32'hC);
        for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);
        // R8: foreign address/modifier writes left the word untouched
        run_vec('{1'b0, 6'h39, 32'h00AB0020, 1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 32'h0A0B0C0D}, 100);
        // R5: odd byte at offset 3 after earlier byte writes
        run_vec('{1'b0, 6'h3D, 32'h00AB0012, 1'b1, 1'b1, 1'b0, 32'h0, 2'd1, 32'h00000066}, 101);
        // R4: upper half read on bus bits [15:0]
        run_vec('{1'b0, 6'h39, 32'h00AB0020, 1'b1, 1'b0, 1'b0, 32'h0, 2'd1, 32'h00000A0B}, 102);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule